// File: doc/BRIEF.md
# Burst Address Sequencer (Two-Bit Beat Order)

This block supplies the address for a four-beat burst on a synchronous SRAM port. When either of two active-low address strobes is low at a rising clock edge, it captures the whole external address. It then steps the two low address bits through four beats, one beat for each clock edge on which the active-low advance input is low. A high advance input suspends the burst on its current beat.

A mode input picks the beat order, and the block samples it only at a load. Low selects a linear wrap, in which the low bits count up modulo four from the loaded value. High selects an interleave, in which the low bits of beat n are the loaded low bits XOR n. The upper address bits pass through the address register unchanged. Chip-enable gating and read/write decisions belong to the surrounding logic.

A two-state controller sequences the block. `ST_IDLE` is entered on reset and means no burst has been loaded. `ST_BURST` means a base address is held. The transitions are:
- IDLE→BURST on a load.
- BURST→BURST on a load, which restarts the burst.
- BURST→BURST on an advance, or on a suspend when the advance input is high.
- any state→IDLE on reset.

Top module: `bseq_top`

## Requirements
- R1: When `strobe_p_n` or `strobe_c_n` is low at a rising edge, `addr_o` equals `addr_i` and `beat_o` equals 0 after that edge, in either order mode.
- R2: A load takes priority over an advance in the same cycle, so the beat count restarts at 0.
- R3: With linear order latched (mode input low at the load), `addr_o[1:0]` equals (loaded low bits + `beat_o`) mod 4.
- R4: With interleaved order latched (mode input high at the load), `addr_o[1:0]` equals the loaded low bits XOR `beat_o`.
- R5: In `ST_BURST` with no strobe, a high `adv_n` leaves `addr_o` and `beat_o` unchanged.
- R6: In `ST_BURST` with no strobe, a low `adv_n` adds 1 to `beat_o` modulo 4. After four advances the address returns to the loaded value.
- R7: `addr_o[ADDR_W-1:2]` changes only at a load or at reset.
- R8: A change on `mode_i` during a burst has no effect until the next load.
- R9: A synchronous reset (`rst` high) sets `addr_o` and `beat_o` to 0 and the controller to `ST_IDLE`.
- R10: In `ST_IDLE`, a low `adv_n` has no effect: `addr_o` and `beat_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_p_n | input | 1 | First address strobe, active low, loads base |
| strobe_c_n | input | 1 | Second address strobe, active low, loads base |
| adv_n | input | 1 | Beat advance, active low |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address bus |
| addr_o | output | ADDR_W | Registered burst address |
| beat_o | output | 2 | Beats advanced since the load |

## Verification
Every result is due one clock edge after its stimulus: a load, an advance, a suspend or a reset all show up on the outputs immediately after the edge that samples them, because only the address register and the beat counter lie on the path. The bench drives its inputs on the falling edge, updates its behavioural model with those same values at the rising edge, and compares `addr_o` and `beat_o` against the model on the next falling edge. In that way each comparison lands exactly one edge after its stimulus.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bseq_order_e;

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_p_n,
    input  logic        strobe_c_n,
    input  logic        adv_n,
    output logic        load_o,
    output logic        step_o,
    output bseq_state_e state_o
);

    bseq_state_e state_q, state_d;
    logic        any_strobe;

    assign any_strobe = ~strobe_p_n | ~strobe_c_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_strobe) state_d = ST_BURST;
            ST_BURST: state_d = ST_BURST;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = any_strobe;
            end
            ST_BURST: begin
                load_o = any_strobe;
                step_o = ~any_strobe & ~adv_n;
            end
            default: begin
                load_o = 1'b0;
                step_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (clr)  count_q <= '0;
        else if (step) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
    import bseq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] base_i,
    input  logic [LOW_W-1:0] beat_i,
    input  bseq_order_e      order_i,
    output logic [LOW_W-1:0] low_o
);

    logic [LOW_W-1:0] lin_bits;
    logic [LOW_W-1:0] ilv_bits;

    assign lin_bits = base_i + beat_i;

    for (genvar g = 0; g < LOW_W; g++) begin : g_ilv
        assign ilv_bits[g] = base_i[g] ^ beat_i[g];
    end

    always_comb begin
        unique case (order_i)
            ORD_LINEAR:     low_o = lin_bits;
            ORD_INTERLEAVE: low_o = ilv_bits;
            default:        low_o = ilv_bits;
        endcase
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LOW_W-1:0]  beat_o
);

    localparam int UP_W = ADDR_W - LOW_W;

    logic             load, step;
    bseq_state_e      state_q;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] base_q;
    bseq_order_e      mode_q;
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] low_bits;

    bseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .adv_n      (adv_n),
        .load_o     (load),
        .step_o     (step),
        .state_o    (state_q)
    );

    bseq_beat_ctr #(.CNT_W(LOW_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .step    (step),
        .count_o (beat)
    );

    // base address and latched order
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            base_q  <= '0;
            mode_q  <= ORD_INTERLEAVE;
        end else if (load) begin
            upper_q <= addr_i[ADDR_W-1:LOW_W];
            base_q  <= addr_i[LOW_W-1:0];
            mode_q  <= bseq_order_e'(mode_i);
        end
    end

    bseq_low_map #(.LOW_W(LOW_W)) u_map (
        .base_i  (base_q),
        .beat_i  (beat),
        .order_i (mode_q),
        .low_o   (low_bits)
    );

    assign addr_o = {upper_q, low_bits};
    assign beat_o = beat;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_p_n,
    input logic              strobe_c_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [LOW_W-1:0]  beat_o,
    input logic              in_burst,
    input logic              ilv_mode
);

    logic ld;
    assign ld = ~strobe_p_n | ~strobe_c_n;

    // R9
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (addr_o == '0 && beat_o == '0 && !in_burst));

    // R1
    a_r1_load_captures: assert property (@(posedge clk) disable iff (rst)
        ld |=> (addr_o == $past(addr_i) && beat_o == '0));

    // R5
    a_r5_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !ld && adv_n) |=> ($stable(addr_o) && $stable(beat_o)));

    // R6
    a_r6_beat_steps: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !ld && !adv_n) |=> (beat_o == $past(beat_o) + 1'b1));

    // R7
    a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(addr_o[ADDR_W-1:LOW_W]));

    // R4
    a_r4_ilv_delta: assert property (@(posedge clk) disable iff (rst)
        (in_burst && ilv_mode && !ld && !adv_n) |=>
        ((addr_o[LOW_W-1:0] ^ $past(addr_o[LOW_W-1:0])) == (beat_o ^ $past(beat_o))));

    // R3
    a_r3_lin_delta: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !ilv_mode && !ld && !adv_n) |=>
        (addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) + 1'b1));

    // R10
    a_r10_idle_ignores_adv: assert property (@(posedge clk) disable iff (rst)
        (!in_burst && !ld) |=> (addr_o == '0 && beat_o == '0));

endmodule

bind bseq_top bseq_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .adv_n      (adv_n),
    .addr_i     (addr_i),
    .addr_o     (addr_o),
    .beat_o     (beat_o),
    .in_burst   (state_q == bseq_pkg::ST_BURST),
    .ilv_mode   (mode_q == bseq_pkg::ORD_INTERLEAVE)
);

// File: tb/tb_bseq_top.sv
module tb_bseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe_p_n = 1'b1;
    logic        strobe_c_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        mode_i = 1'b1;
    logic [15:0] addr_i = '0;
    logic [15:0] addr_o;
    logic [1:0]  beat_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    int m_upper = 0, m_base = 0, m_beat = 0, m_mode = 1;
    bit m_active = 0;

    always #5 clk = ~clk;

    bseq_top dut (
        .clk(clk), .rst(rst), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .mode_i(mode_i), .addr_i(addr_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    function automatic int exp_addr();
        int low;
        if (m_mode != 0) low = m_base ^ m_beat;
        else             low = (m_base + m_beat) % 4;
        return m_upper * 4 + low;
    endfunction

    task automatic cyc(input bit r, input bit sp, input bit sc, input bit av,
                       input bit md, input logic [15:0] a, input string req);
        int ea;
        rst = r; strobe_p_n = sp; strobe_c_n = sc; adv_n = av;
        mode_i = md; addr_i = a;
        @(posedge clk);
        if (r) begin
            m_upper = 0; m_base = 0; m_beat = 0; m_mode = 1; m_active = 0;
        end else if (!sp || !sc) begin
            m_upper = int'(a[15:2]); m_base = int'(a[1:0]);
            m_beat = 0; m_mode = md ? 1 : 0; m_active = 1;
        end else if (m_active && !av) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        ea = exp_addr();
        n_cmp++;
        if (int'(addr_o) != ea || int'(beat_o) != m_beat) begin
            n_bad++;
            $display("FAIL %s: addr_o=%h beat_o=%0d expected addr=%h beat=%0d",
                     req, addr_o, beat_o, ea[15:0], m_beat);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1, 1, 1, 1, 1, 16'hFFFF, "R9 reset");
        cyc(1, 1, 1, 0, 1, 16'hFFFF, "R9 reset");
        // R10: advance while idle
        cyc(0, 1, 1, 0, 1, 16'h5555, "R10 idle adv");
        cyc(0, 1, 1, 0, 0, 16'h5555, "R10 idle adv");
        // R1 + R3: linear from low bits 10 via first strobe
        cyc(0, 0, 1, 1, 0, 16'h1232, "R1 load p");
        cyc(0, 1, 1, 0, 0, 16'h0000, "R3 lin beat1");
        cyc(0, 1, 1, 1, 1, 16'hFFFF, "R5 suspend");
        cyc(0, 1, 1, 1, 1, 16'hFFFF, "R5 suspend");
        cyc(0, 1, 1, 0, 1, 16'h0000, "R8 mode change ignored");
        cyc(0, 1, 1, 0, 1, 16'h0000, "R3 lin beat3");
        cyc(0, 1, 1, 0, 0, 16'h0000, "R6 wrap to base");
        cyc(0, 1, 1, 0, 0, 16'h0000, "R7 upper held");
        // R4: interleave from 01 via second strobe
        cyc(0, 1, 0, 1, 1, 16'hABC1, "R1 load c");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, 16'h0000, "R4 ilv beat");
        // interleave from 10
        cyc(0, 0, 0, 0, 1, 16'h00F2, "R2 load over adv");
        cyc(0, 1, 1, 0, 1, 16'h00F2, "R4 ilv 10 beat1");
        cyc(0, 1, 1, 0, 1, 16'h00F2, "R4 ilv 10 beat2");
        cyc(0, 0, 1, 0, 0, 16'h7773, "R2 reload mid-burst");
        cyc(0, 1, 1, 0, 0, 16'h0000, "R3 lin from 11");
        cyc(1, 1, 1, 0, 0, 16'h0000, "R9 reset mid-burst");
        cyc(0, 1, 1, 0, 0, 16'h0000, "R10 idle after reset");
        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            int k;
            a = 16'($urandom);
            k = $urandom % 8;
            cyc(0, k != 0, k != 1, ($urandom % 3) == 0, 1'($urandom), a, "R1 R3 R4 R5 R6 mixed");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule